// File: doc/BRIEF.md
# Integer Arithmetic Unit with Carry and Overflow Flags

This block is the arithmetic execution unit of a 32-bit RISC pipeline. A caller presents two operands, a 3-bit operation code, the core's current carry flag and a trap-enable bit for arithmetic overflow, and pulses `start`. The unit returns the result together with freshly computed carry and overflow flags. When the trap enable is set and the completed operation ends in an error condition, it also raises a one-cycle request for a range exception. Taking the exception is left to the core.

Addition, addition with carry, subtraction and both multiplies complete in one cycle. Both divides use a bit-serial restoring divider and stay busy for the width of the operand. Every completion is marked by a one-cycle `done` pulse. Outputs and flags are registered on that completion and hold until the next one. A divide by zero reports through the carry flag and drops `result_we`, so the destination register is not written.

Top module: `flagged_int_alu`

## Requirements
- R1: Opcode 0 adds A and B; result is the low 32 bits, CY is the carry out of bit 31, OV is set when both operands share a sign bit that differs from the result's sign bit.
- R2: Opcode 1 adds A, B and carry_in; CY is the carry out of bit 31 (so 0 + 0xFFFFFFFF with carry_in 1 gives result 0 and CY 1), OV uses the same sign rule as R1.
- R3: Opcode 2 computes A minus B; CY is set exactly when B as unsigned exceeds A, OV is set when A and B differ in sign and the result's sign differs from A's.
- R4: Opcode 3 multiplies as signed and returns the low 32 bits of the product; OV is set when the signed product falls outside the signed 32-bit range, CY when the unsigned product of the same bits exceeds 0xFFFFFFFF.
- R5: Opcode 4 multiplies as unsigned, returns the low 32 bits, always clears OV and sets CY when the product exceeds 0xFFFFFFFF.
- R6: Opcodes 5 (signed) and 6 (unsigned) divide A by a nonzero B; the quotient truncates toward zero, result_we is 1, CY and OV are cleared; 0x80000000 divided by -1 gives 0x80000000 with no flag.
- R7: A divide with B equal to zero sets CY, clears OV, holds result_we low with done, and leaves result at its previous value.
- R8: range_req pulses with done when trap_en was set at start and OV is set after opcodes 0 to 3, or CY is set after a divide; otherwise it stays low.
- R9: done is a one-cycle pulse seen 1 cycle after the start edge for opcodes 0 to 4, 2 cycles after it for a zero divisor and 34 cycles after it for a nonzero divide.
- R10: While busy is high, start is ignored, and opcode 7 is reserved: it starts nothing, gives no done and changes no output.
- R11: After reset, result, result_we, cy_out, ov_out, range_req, done and busy are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation, accepted when busy is low |
| op | input | 3 | Operation code (see R1 to R10) |
| opa | input | 32 | Operand A (divide: dividend) |
| opb | input | 32 | Operand B (divide: divisor) |
| carry_in | input | 1 | Current carry flag, used by opcode 1 |
| trap_en | input | 1 | Enables the range-exception request |
| busy | output | 1 | A divide is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Registered result |
| result_we | output | 1 | With done: destination should be written |
| cy_out | output | 1 | Registered carry flag |
| ov_out | output | 1 | Registered overflow flag |
| range_req | output | 1 | One-cycle range-exception request |

## Verification
Several properties are checked on every clock cycle: the subtract borrow against an unsigned comparison of the operands, the cleared overflow after an unsigned multiply and after every divide, a held result on divide by zero, the link between a range request and a set flag, and the single-cycle shape of the divider's finish pulse. The arithmetic values can only be shown by the bench's scenarios, which compare them with independently computed 64-bit results. Those scenarios cover signed products that sit exactly at the range limits, the most-negative-by-minus-one quotient, carry-in wrap, the latency of each path, and a start issued during a divide.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUB  = 3'd2,
    OP_MULS = 3'd3,
    OP_MULU = 3'd4,
    OP_DIVS = 3'd5,
    OP_DIVU = 3'd6,
    OP_RSVD = 3'd7
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cy,
  output logic         ov
);
  logic [W-1:0] b_x;
  logic         c_x;
  logic [W:0]   ext;

  always_comb begin
    b_x = sub ? ~b : b;
    c_x = sub ? 1'b1 : cin;
    ext = {1'b0, a} + {1'b0, b_x} + {{W{1'b0}}, c_x};
    sum = ext[W-1:0];
    // carry out for add, inverted carry (borrow) for subtract
    cy  = sub ? ~ext[W] : ext[W];
    // same-sign inputs to the adder producing a flipped sign
    ov  = (a[W-1] == b_x[W-1]) && (ext[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         is_signed,
  output logic [W-1:0] prod_lo,
  output logic         cy,
  output logic         ov
);
  logic [2*W-1:0] uprod;
  logic [W-1:0]   uhi;
  logic [W-1:0]   shi;

  // one unsigned array; the signed high half is corrected from it
  always_comb begin
    uprod   = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    prod_lo = uprod[W-1:0];
    uhi     = uprod[2*W-1:W];
    shi     = uhi - (a[W-1] ? b : '0) - (b[W-1] ? a : '0);
    cy      = |uhi;
    ov      = is_signed && (shi != {W{prod_lo[W-1]}});
  end
endmodule

// File: rtl/alu_divider.sv
module alu_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         fin,
  output logic         div_zero,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rem, quo, dvs;
  logic          neg;
  logic [W:0]    shifted, diff;
  logic [W-1:0]  nrem, nquo;
  logic [W-1:0]  mag_a, mag_b;

  always_comb begin
    mag_a = (is_signed && dividend[W-1]) ? (~dividend + 1'b1) : dividend;
    mag_b = (is_signed && divisor[W-1])  ? (~divisor + 1'b1)  : divisor;
    // one restoring step: shift in next dividend bit, trial subtract
    shifted = {rem, quo[W-1]};
    diff    = shifted - {1'b0, dvs};
    if (diff[W]) begin
      nrem = shifted[W-1:0];
      nquo = {quo[W-2:0], 1'b0};
    end else begin
      nrem = diff[W-1:0];
      nquo = {quo[W-2:0], 1'b1};
    end
    quotient = neg ? (~quo + 1'b1) : quo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      fin      <= 1'b0;
      div_zero <= 1'b0;
      cnt      <= '0;
      rem      <= '0;
      quo      <= '0;
      dvs      <= '0;
      neg      <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start && !active) begin
        if (divisor == '0) begin
          fin      <= 1'b1;
          div_zero <= 1'b1;
        end else begin
          div_zero <= 1'b0;
          active   <= 1'b1;
          cnt      <= CW'(W);
          rem      <= '0;
          quo      <= mag_a;
          dvs      <= mag_b;
          neg      <= is_signed && (dividend[W-1] ^ divisor[W-1]);
        end
      end else if (active) begin
        rem <= nrem;
        quo <= nquo;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end
      end
    end
  end

  AST_FIN_PULSE: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin); // R9
  AST_FIN_IDLE: assert property (@(posedge clk) disable iff (rst)
    fin |-> !active); // R9
endmodule

// File: rtl/flagged_int_alu.sv
module flagged_int_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         carry_in,
  input  logic         trap_en,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic         cy_out,
  output logic         ov_out,
  output logic         range_req
);
  import alu_pkg::*;

  alu_op_e      op_e;
  logic         accept, is_div, is_fast;
  logic [W-1:0] as_sum, mul_lo, div_q;
  logic         as_cy, as_ov, mul_cy, mul_ov;
  logic         div_fin, div_zero;
  logic [W-1:0] f_res;
  logic         f_cy, f_ov, f_trap;
  logic         en_q;

  assign op_e    = alu_op_e'(op);
  assign accept  = start && !busy;
  assign is_div  = (op_e == OP_DIVS) || (op_e == OP_DIVU);
  assign is_fast = !is_div && (op_e != OP_RSVD);

  alu_addsub #(.W(W)) u_addsub (
    .a(opa), .b(opb),
    .sub(op_e == OP_SUB),
    .cin((op_e == OP_ADDC) && carry_in),
    .sum(as_sum), .cy(as_cy), .ov(as_ov)
  );

  alu_mul #(.W(W)) u_mul (
    .a(opa), .b(opb),
    .is_signed(op_e == OP_MULS),
    .prod_lo(mul_lo), .cy(mul_cy), .ov(mul_ov)
  );

  alu_divider #(.W(W)) u_div (
    .clk(clk), .rst(rst),
    .start(accept && is_div),
    .is_signed(op_e == OP_DIVS),
    .dividend(opa), .divisor(opb),
    .fin(div_fin), .div_zero(div_zero), .quotient(div_q)
  );

  always_comb begin
    if ((op_e == OP_MULS) || (op_e == OP_MULU)) begin
      f_res = mul_lo;
      f_cy  = mul_cy;
      f_ov  = mul_ov;
    end else begin
      f_res = as_sum;
      f_cy  = as_cy;
      f_ov  = as_ov;
    end
    f_trap = trap_en && f_ov;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      result    <= '0;
      result_we <= 1'b0;
      cy_out    <= 1'b0;
      ov_out    <= 1'b0;
      range_req <= 1'b0;
      en_q      <= 1'b0;
    end else begin
      done      <= 1'b0;
      result_we <= 1'b0;
      range_req <= 1'b0;
      if (accept && is_fast) begin
        result    <= f_res;
        result_we <= 1'b1;
        cy_out    <= f_cy;
        ov_out    <= f_ov;
        range_req <= f_trap;
        done      <= 1'b1;
      end else if (accept && is_div) begin
        busy <= 1'b1;
        en_q <= trap_en;
      end
      if (div_fin) begin
        busy      <= 1'b0;
        done      <= 1'b1;
        ov_out    <= 1'b0;
        cy_out    <= div_zero;
        result_we <= !div_zero;
        range_req <= en_q && div_zero;
        if (!div_zero) result <= div_q;
      end
    end
  end

  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
    (accept && op_e == OP_SUB) |=> (cy_out == ($past(opb) > $past(opa)))); // R3
  AST_MULU_NO_OV: assert property (@(posedge clk) disable iff (rst)
    (accept && op_e == OP_MULU) |=> (done && !ov_out)); // R5
  AST_DIV_OV_CLEAR: assert property (@(posedge clk) disable iff (rst)
    div_fin |=> (done && !ov_out)); // R6
  AST_DZ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !result_we) |-> (cy_out && $stable(result))); // R7
  AST_RANGE_FLAG: assert property (@(posedge clk) disable iff (rst)
    range_req |-> (done && (ov_out || cy_out))); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && !div_fin) |=> busy); // R10
endmodule

// File: tb/flagged_int_alu_bench.sv
module flagged_int_alu_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [2:0]   op = 3'd0;
  logic [W-1:0] opa = '0, opb = '0;
  logic         carry_in = 1'b0, trap_en = 1'b0;
  logic         busy, done, result_we, cy_out, ov_out, range_req;
  logic [W-1:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  logic [W-1:0] hold_res = '0;

  always #2.5 clk = ~clk;

  flagged_int_alu #(.W(W)) u_flagged_int_alu (
    .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
    .carry_in(carry_in), .trap_en(trap_en), .busy(busy), .done(done),
    .result(result), .result_we(result_we), .cy_out(cy_out),
    .ov_out(ov_out), .range_req(range_req)
  );

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string op_tag(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic void model(input logic [2:0] o, input logic [W-1:0] a, b,
                                input logic ci, en, input logic [W-1:0] prev,
                                output logic [W-1:0] r, output logic cy, ov, we, rr);
    logic [W:0]   s;
    longint       sp, sq;
    logic [63:0]  up;
    we = 1'b1; r = prev; cy = 1'b0; ov = 1'b0;
    case (o)
      3'd0, 3'd1: begin
        s  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, (o == 3'd1) && ci};
        r  = s[W-1:0];
        cy = s[W];
        ov = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
      end
      3'd2: begin
        r  = a - b;
        cy = b > a;
        ov = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
      end
      3'd3, 3'd4: begin
        up = {32'd0, a} * {32'd0, b};
        sp = longint'($signed(a)) * longint'($signed(b));
        r  = up[31:0];
        cy = up[63:32] != 0;
        ov = (o == 3'd3) && ((sp < -64'sd2147483648) || (sp > 64'sd2147483647));
      end
      default: begin
        if (b == 0) begin
          cy = 1'b1; we = 1'b0;
        end else if (o == 3'd5) begin
          sq = longint'($signed(a)) / longint'($signed(b));
          r  = sq[31:0];
        end else begin
          r = a / b;
        end
      end
    endcase
    rr = en && ((o >= 3'd5) ? cy : ov);
  endfunction

  task automatic run_op(input logic [2:0] o, input logic [W-1:0] a, b,
                        input logic ci, en);
    logic [W-1:0] er;
    logic ecy, eov, ewe, err;
    int lat, exp_lat;
    string tg;
    model(o, a, b, ci, en, hold_res, er, ecy, eov, ewe, err);
    tg = op_tag(o);
    exp_lat = (o < 3'd5) ? 1 : ((b == 0) ? 2 : W + 2);
    @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b; carry_in = ci; trap_en = en;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    check("R9 latency", lat, exp_lat);
    if (o >= 3'd5 && b == 0) begin
      check("R7 result held", result, hold_res);
      check("R7 we", {31'd0, result_we}, 32'd0);
      check("R7 cy", {31'd0, cy_out}, 32'd1);
    end else begin
      check({tg, " result"}, result, er);
      check({tg, " we"}, {31'd0, result_we}, {31'd0, ewe});
      check({tg, " cy"}, {31'd0, cy_out}, {31'd0, ecy});
    end
    check({tg, " ov"}, {31'd0, ov_out}, {31'd0, eov});
    check("R8 range_req", {31'd0, range_req}, {31'd0, err});
    if (ewe) hold_res = er;
    @(negedge clk);
    check("R9 done pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 result", result, '0);
    check("R11 flags", {25'd0, busy, done, result_we, cy_out, ov_out, range_req, 1'b0}, 32'd0);

    // directed corners
    run_op(3'd0, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b1);         // R1 ov + R8
    run_op(3'd0, 32'hFFFF_FFFF, 32'h1, 1'b1, 1'b0);         // R1 cy, carry ignored
    run_op(3'd1, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b0);         // R2 wrap
    run_op(3'd1, 32'h0, 32'hFFFF_FFFF, 1'b0, 1'b0);         // R2 no carry
    run_op(3'd2, 32'h0, 32'h1, 1'b0, 1'b0);                 // R3 borrow
    run_op(3'd2, 32'h8000_0000, 32'h1, 1'b0, 1'b1);         // R3 ov + R8
    run_op(3'd3, 32'h0001_0000, 32'h0000_8000, 1'b0, 1'b1); // R4 just out of range
    run_op(3'd3, 32'hFFFF_0000, 32'h0000_8000, 1'b0, 1'b1); // R4 exactly min
    run_op(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0); // R4 cy without ov
    run_op(3'd4, 32'hFFFF_FFFF, 32'h2, 1'b0, 1'b1);         // R5
    run_op(3'd5, 32'hFFFF_FFF9, 32'h2, 1'b0, 1'b1);         // R6 -7/2
    run_op(3'd5, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1); // R6 min/-1
    run_op(3'd6, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0);         // R6
    run_op(3'd5, 32'h1234_5678, 32'h0, 1'b0, 1'b1);         // R7 + R8
    run_op(3'd6, 32'h9, 32'h0, 1'b0, 1'b0);                 // R7

    // R10: start during a divide is ignored
    @(negedge clk);
    start = 1'b1; op = 3'd6; opa = 32'd100; opb = 32'd7; trap_en = 1'b0;
    @(negedge clk);
    start = 1'b1; op = 3'd0; opa = 32'd1; opb = 32'd2;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 60 && !done; i++) @(negedge clk);
    check("R10 busy start ignored", result, 32'd14);
    hold_res = 32'd14;
    repeat (3) begin
      @(negedge clk);
      check("R10 no extra done", {31'd0, done}, 32'd0);
    end

    // R10: reserved opcode 7
    @(negedge clk);
    start = 1'b1; op = 3'd7; opa = 32'h55; opb = 32'h66;
    @(negedge clk);
    start = 1'b0;
    repeat (4) begin
      check("R10 reserved no done", {30'd0, done, busy}, 32'd0);
      @(negedge clk);
    end
    check("R10 reserved result", result, 32'd14);

    // constrained random
    for (int k = 0; k < 300; k++) begin
      logic [2:0]   ro;
      logic [W-1:0] ra, rb;
      ro = 3'($urandom % 7);
      ra = $urandom;
      rb = $urandom;
      case ($urandom % 6)
        0: rb = 32'($urandom % 16);
        1: ra = {{16{ra[15]}}, ra[15:0]};
        2: rb = {{17{rb[14]}}, rb[14:0]};
        default: ;
      endcase
      run_op(ro, ra, rb, 1'($urandom), 1'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule